// File: doc/BRIEF.md
# Protected System Clock Control Register

This block is an 8-bit clock control register for a microcontroller-style system controller. Software writes it through a simple write strobe, and each write lands only while an external protect (unlock) bit is set. The stored fields choose what the clock output pin carries, whether peripheral clocks halt during wait mode, whether the sub-oscillator runs, whether the main oscillator is stopped, what the watchdog does on expiry, and which oscillator drives the system clock.

The block also enforces the rules tied to those fields. The watchdog action bit can be set but not cleared. Stopping the main oscillator sends a one-cycle load pulse to a neighbouring divider so that it drops to divide-by-8, unless ring-oscillator mode is active. A change of clock source is refused unless the target oscillator reports stable. Changing both oscillator control bits in one write is flagged. The chosen source drives the system clock through a handshake that never lets both oscillators through at once, and each gate opens or closes only on the low phase of its own oscillator.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset `rd_data` reads 0x00, both error pulses and `div8_load` are 0, and the main oscillator is the selected source.
- R2: A write while `unlock` is 0 leaves every stored bit unchanged and raises `err_pulse` for exactly the one cycle after the write.
- R3: Bits 1:0 are the pin code and `clkout_src` mirrors them (01 = fC, 10 = divide-by-8, 11 = divide-by-32). Code 00 gives `pin_gpio`=1 when `bus_mode` is 0, or `pin_ale`=1 when `bus_mode` is 1. Any other code clears both.
- R4: Bit 2 set drives `periph_stop_wait`=1 and `pll_wait_ok`=0. Bit 2 clear gives the inverse.
- R5: Bit 4 drives `sub_osc_en`. Bit 5 drives both `main_osc_stop` and `xout_high`.
- R6: An accepted write that takes bit 5 from 0 to 1 while `ring_osc_mode` is 0 raises `div8_load` for one cycle. With `ring_osc_mode` 1, or when bit 5 was already 1, no pulse occurs.
- R7: Bit 6 (0 = watchdog interrupt, 1 = watchdog reset) becomes 1 on an accepted write of 1 and stays 1 through later writes of 0 until reset. `wdt_reset_mode` mirrors it.
- R8: An accepted write that changes bit 7 (0 = main, 1 = sub) takes effect only if `sub_stable` (for 0 to 1) or `main_stable` (for 1 to 0) is 1. Otherwise bit 7 keeps its value, `err_pulse` is raised for one cycle, and the other fields of the write still apply.
- R9: An accepted write whose bits 4 and 5 both differ from the stored values raises `usage_err` for one cycle. The write is still applied.
- R10: Bit 3 ignores writes and always reads 0.
- R11: `main_gate_on` and `sub_gate_on` are never 1 together. Some tens of bus cycles after bit 7 changes, only the gate of the selected source is 1.
- R12: Once the handshake has settled, `sys_clk` follows the selected oscillator and ignores the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| unlock | input | 1 | Protect bit; writes land only while 1 |
| bus_mode | input | 1 | 1 = processor/memory-expansion mode |
| ring_osc_mode | input | 1 | Ring oscillator in use; suppresses divide-by-8 forcing |
| main_stable | input | 1 | Main oscillator stable flag |
| sub_stable | input | 1 | Sub-oscillator stable flag |
| osc_main | input | 1 | Main oscillator clock |
| osc_sub | input | 1 | Sub-oscillator clock |
| rd_data | output | 8 | Register readback |
| pin_gpio | output | 1 | Clock pin acts as plain I/O |
| pin_ale | output | 1 | Clock pin carries address-latch strobe |
| clkout_src | output | 2 | Clock pin source code |
| periph_stop_wait | output | 1 | Gate peripheral clocks in wait mode |
| pll_wait_ok | output | 1 | PLL usable in wait mode |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| main_osc_stop | output | 1 | Main oscillator stop |
| xout_high | output | 1 | Hold main oscillator output pin high |
| wdt_reset_mode | output | 1 | Watchdog expiry resets instead of interrupting |
| div8_load | output | 1 | One-cycle pulse forcing the divider to divide-by-8 |
| err_pulse | output | 1 | Blocked write or refused source switch |
| usage_err | output | 1 | Both oscillator control bits changed in one write |
| main_gate_on | output | 1 | Main oscillator gated onto the system clock |
| sub_gate_on | output | 1 | Sub-oscillator gated onto the system clock |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
The bench targets these cases. A write with the protect bit low must leave the register unchanged; a design that applied it would corrupt the readback and miss the error pulse. A later write of 0 to the watchdog bit must not clear it, which a plain register bit would allow. A source switch requested while the target oscillator is unstable must be refused while the other fields of the same write still apply, so a design that dropped the whole write, or took the switch anyway, shows up in the readback. The divide-by-8 pulse is exercised with and without ring-oscillator mode, the both-bits usage error is exercised, and the system clock is traced edge by edge after each switch to catch a mux that passes the wrong oscillator or opens both gates.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
// Shared field positions, pin function encoding and helper functions for
// the system clock control register. Assumes an 8-bit register.
package sysclk_pkg;
    localparam int REG_W      = 8;
    localparam int B_PIN_LO   = 0;
    localparam int B_PIN_HI   = 1;
    localparam int B_WAITSTOP = 2;
    localparam int B_UNUSED   = 3;
    localparam int B_SUB_EN   = 4;
    localparam int B_MAIN_OFF = 5;
    localparam int B_WDT_RST  = 6;
    localparam int B_SRC_SUB  = 7;
    localparam int PIN_W      = B_PIN_HI - B_PIN_LO + 1;

    typedef enum logic [PIN_W-1:0] {
        PIN_PORT = 2'b00,
        PIN_FC   = 2'b01,
        PIN_F8   = 2'b10,
        PIN_F32  = 2'b11
    } pin_fn_e;

    // True when the requested source may be taken given oscillator status.
    function automatic logic switch_ok(input logic want_sub,
                                       input logic sub_ok,
                                       input logic main_ok);
        return want_sub ? sub_ok : main_ok;
    endfunction
endpackage

// File: rtl/sysclk_regfile.sv
`timescale 1ns/1ps
// Register storage with write protection, sticky watchdog bit, guarded
// source bit, and one-cycle event pulses. All logic is in the bus domain.
// Assumes wr_en is a single-cycle strobe.
module sysclk_regfile
    import sysclk_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             unlock,
    input  logic             ring_osc_mode,
    input  logic             main_stable,
    input  logic             sub_stable,
    output logic [REG_W-1:0] cfg,
    output logic             div8_load,
    output logic             err_pulse,
    output logic             usage_err
);
    logic [REG_W-1:0] cfg_nxt;
    logic             blocked, refused, clash, stop_edge;

    // Work out the next register value and the events this write raises.
    always_comb begin
        cfg_nxt   = cfg;
        blocked   = 1'b0;
        refused   = 1'b0;
        clash     = 1'b0;
        stop_edge = 1'b0;
        if (wr_en && !unlock) begin
            blocked = 1'b1;
        end else if (wr_en) begin
            cfg_nxt[B_PIN_HI:B_PIN_LO] = wr_data[B_PIN_HI:B_PIN_LO];
            cfg_nxt[B_WAITSTOP]        = wr_data[B_WAITSTOP];
            cfg_nxt[B_UNUSED]          = 1'b0;
            cfg_nxt[B_SUB_EN]          = wr_data[B_SUB_EN];
            cfg_nxt[B_MAIN_OFF]        = wr_data[B_MAIN_OFF];
            cfg_nxt[B_WDT_RST]         = cfg[B_WDT_RST] | wr_data[B_WDT_RST];
            if (wr_data[B_SRC_SUB] != cfg[B_SRC_SUB]) begin
                if (switch_ok(wr_data[B_SRC_SUB], sub_stable, main_stable))
                    cfg_nxt[B_SRC_SUB] = wr_data[B_SRC_SUB];
                else
                    refused = 1'b1;
            end
            clash = (wr_data[B_SUB_EN] != cfg[B_SUB_EN]) &&
                    (wr_data[B_MAIN_OFF] != cfg[B_MAIN_OFF]);
            stop_edge = wr_data[B_MAIN_OFF] && !cfg[B_MAIN_OFF] && !ring_osc_mode;
        end
    end

    // Store the register and register the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= RESET_VAL;
            div8_load <= 1'b0;
            err_pulse <= 1'b0;
            usage_err <= 1'b0;
        end else begin
            cfg       <= cfg_nxt;
            div8_load <= stop_edge;
            err_pulse <= blocked | refused;
            usage_err <= clash;
        end
    end
endmodule

// File: rtl/sysclk_pin_decode.sv
`timescale 1ns/1ps
// Decodes the clock output pin code into pin role signals. Code 00 is
// a plain port in single-chip mode and the address-latch strobe in bus mode.
module sysclk_pin_decode
    import sysclk_pkg::*;
(
    input  logic [PIN_W-1:0] code,
    input  logic             bus_mode,
    output logic             pin_gpio,
    output logic             pin_ale,
    output logic [PIN_W-1:0] clkout_src
);
    pin_fn_e fn;

    // Map the code onto the pin role.
    always_comb begin
        fn         = pin_fn_e'(code);
        pin_gpio   = (fn == PIN_PORT) && !bus_mode;
        pin_ale    = (fn == PIN_PORT) && bus_mode;
        clkout_src = code;
    end
endmodule

// File: rtl/sysclk_gate_side.sv
`timescale 1ns/1ps
// One side of the glitch-free clock mux. Each side synchronises its request,
// qualified by the other side being off, into its own oscillator domain,
// then opens or closes the gate on the falling edge so no runt pulse forms.
// Assumes the oscillator runs while reset is asserted.
module sysclk_gate_side #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_on,
    output logic gate_on
);
    localparam int LAST = SYNC_STAGES - 1;
    logic [SYNC_STAGES-1:0] sync_q;

    // Bring the qualified request into the oscillator domain.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], want & ~other_on};
    end

    // Change the gate only while the oscillator is low.
    always_ff @(negedge osc_clk) begin
        if (!rst_n) gate_on <= 1'b0;
        else        gate_on <= sync_q[LAST];
    end
endmodule

// File: rtl/sysclk_ctl.sv
`timescale 1ns/1ps
// Top of the protected system clock control register. Combines the
// register file, the pin decoder and the two-sided glitch-free clock mux,
// and maps register fields onto control outputs.
module sysclk_ctl
    import sysclk_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [REG_W-1:0] RESET_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             unlock,
    input  logic             bus_mode,
    input  logic             ring_osc_mode,
    input  logic             main_stable,
    input  logic             sub_stable,
    input  logic             osc_main,
    input  logic             osc_sub,
    output logic [REG_W-1:0] rd_data,
    output logic             pin_gpio,
    output logic             pin_ale,
    output logic [PIN_W-1:0] clkout_src,
    output logic             periph_stop_wait,
    output logic             pll_wait_ok,
    output logic             sub_osc_en,
    output logic             main_osc_stop,
    output logic             xout_high,
    output logic             wdt_reset_mode,
    output logic             div8_load,
    output logic             err_pulse,
    output logic             usage_err,
    output logic             main_gate_on,
    output logic             sub_gate_on,
    output logic             sys_clk
);
    localparam int NSRC = 2;
    logic [REG_W-1:0] cfg;
    logic [NSRC-1:0]  osc_v, want_v, gate_v;

    sysclk_regfile #(.RESET_VAL(RESET_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .unlock(unlock), .ring_osc_mode(ring_osc_mode),
        .main_stable(main_stable), .sub_stable(sub_stable),
        .cfg(cfg), .div8_load(div8_load), .err_pulse(err_pulse),
        .usage_err(usage_err)
    );

    sysclk_pin_decode u_pin (
        .code(cfg[B_PIN_HI:B_PIN_LO]), .bus_mode(bus_mode),
        .pin_gpio(pin_gpio), .pin_ale(pin_ale), .clkout_src(clkout_src)
    );

    // Drive field outputs straight from the stored register.
    always_comb begin
        rd_data          = cfg;
        periph_stop_wait = cfg[B_WAITSTOP];
        pll_wait_ok      = ~cfg[B_WAITSTOP];
        sub_osc_en       = cfg[B_SUB_EN];
        main_osc_stop    = cfg[B_MAIN_OFF];
        xout_high        = cfg[B_MAIN_OFF];
        wdt_reset_mode   = cfg[B_WDT_RST];
    end

    // Index 0 is the main oscillator, index 1 the sub-oscillator.
    always_comb begin
        osc_v  = {osc_sub, osc_main};
        want_v = {cfg[B_SRC_SUB], ~cfg[B_SRC_SUB]};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_side
        sysclk_gate_side #(.SYNC_STAGES(SYNC_STAGES)) u_side (
            .osc_clk(osc_v[g]), .rst_n(rst_n), .want(want_v[g]),
            .other_on(gate_v[NSRC-1-g]), .gate_on(gate_v[g])
        );
    end

    // Combine the gated oscillators onto the system clock.
    always_comb begin
        main_gate_on = gate_v[0];
        sub_gate_on  = gate_v[1];
        sys_clk      = |(osc_v & gate_v);
    end
endmodule

// File: rtl/sysclk_ctl_chk.sv
`timescale 1ns/1ps
// Property checker for sysclk_ctl, attached through bind.
module sysclk_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       unlock,
    input logic       main_stable,
    input logic       sub_stable,
    input logic [7:0] rd_data,
    input logic       div8_load,
    input logic       err_pulse,
    input logic       main_gate_on,
    input logic       sub_gate_on
);
    a_r2_blocked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock) |=> $stable(rd_data));
    a_r2_blocked_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock) |=> err_pulse);
    a_r6_div8_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        div8_load |-> (rd_data[5] && !$past(rd_data[5])));
    a_r7_wdt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data[6]) |-> rd_data[6]);
    a_r8_sub_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[7]) |-> $past(sub_stable));
    a_r8_main_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[7]) |-> $past(main_stable));
    a_r10_bit3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3]);
    a_r11_one_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_gate_on && sub_gate_on));
endmodule

bind sysclk_ctl sysclk_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .unlock(unlock),
    .main_stable(main_stable), .sub_stable(sub_stable), .rd_data(rd_data),
    .div8_load(div8_load), .err_pulse(err_pulse),
    .main_gate_on(main_gate_on), .sub_gate_on(sub_gate_on)
);

// File: tb/sysclk_ctl_tb.sv
`timescale 1ns/1ps
module sysclk_ctl_tb;
    localparam real CLK_PERIOD = 10.0;
    localparam int  WDOG_LIMIT = 20000;

    logic clk = 0, rst_n = 0, wr_en = 0, unlock = 0, bus_mode = 0;
    logic ring_osc_mode = 0, main_stable = 1, sub_stable = 1;
    logic osc_main = 0, osc_sub = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [1:0] clkout_src;
    logic pin_gpio, pin_ale, periph_stop_wait, pll_wait_ok, sub_osc_en;
    logic main_osc_stop, xout_high, wdt_reset_mode, div8_load, err_pulse;
    logic usage_err, main_gate_on, sub_gate_on, sys_clk;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // reference model state
    int m_reg = 0;
    bit m_err = 0, m_use = 0, m_div8 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #3.5 osc_main = ~osc_main;
    always #11.5 osc_sub = ~osc_sub;

    sysclk_ctl u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, evaluated on each bus edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_reg = 0; m_err = 0; m_use = 0; m_div8 = 0;
        end else begin
            m_err = 0; m_use = 0; m_div8 = 0;
            if (wr_en && !unlock) m_err = 1;
            else if (wr_en) begin
                int nv;
                nv = wr_data & 8'h37;
                if (((m_reg >> 6) & 1) || wr_data[6]) nv |= 8'h40;
                if (wr_data[7] != m_reg[7]) begin
                    if ((wr_data[7] && sub_stable) || (!wr_data[7] && main_stable))
                        nv |= (wr_data[7] ? 8'h80 : 0);
                    else begin
                        nv |= (m_reg & 8'h80);
                        m_err = 1;
                    end
                end else nv |= (m_reg & 8'h80);
                m_use = (wr_data[4] != m_reg[4]) && (wr_data[5] != m_reg[5]);
                m_div8 = wr_data[5] && !m_reg[5] && !ring_osc_mode;
                m_reg = nv;
            end
        end
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // compare every bus cycle away from the active edge
    always @(negedge clk) begin
        int code;
        code = m_reg & 3;
        chk("R7 rd_data", rd_data, m_reg);
        chk("R2 err_pulse", err_pulse, m_err);
        chk("R9 usage_err", usage_err, m_use);
        chk("R6 div8_load", div8_load, m_div8);
        chk("R3 clkout_src", clkout_src, code);
        chk("R3 pin_gpio", pin_gpio, (code == 0) && !bus_mode);
        chk("R3 pin_ale", pin_ale, (code == 0) && bus_mode);
        chk("R4 periph_stop_wait", periph_stop_wait, m_reg[2]);
        chk("R4 pll_wait_ok", pll_wait_ok, !m_reg[2]);
        chk("R5 sub_osc_en", sub_osc_en, m_reg[4]);
        chk("R5 main_osc_stop", main_osc_stop, m_reg[5]);
        chk("R5 xout_high", xout_high, m_reg[5]);
        chk("R7 wdt_reset_mode", wdt_reset_mode, m_reg[6]);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic wr(input logic [7:0] d, input logic unl);
        wr_data = d; unlock = unl; wr_en = 1;
        step(1);
        wr_en = 0;
        step(1);
    endtask

    // trace the system clock against one oscillator for a few edges
    task automatic trace(input bit use_sub, input string req);
        for (int i = 0; i < 4; i++) begin
            if (use_sub) @(posedge osc_sub); else @(posedge osc_main);
            #1 chk(req, sys_clk, 1);
            if (use_sub) @(negedge osc_sub); else @(negedge osc_main);
            #1 chk(req, sys_clk, 0);
        end
        step(1);
    endtask

    initial begin
        step(4);
        rst_n = 1;
        step(40);
        chk("R1 reset rd_data", rd_data, 0);
        chk("R1 reset err", err_pulse, 0);
        chk("R11 main gate after reset", main_gate_on, 1);
        trace(0, "R12 main after reset");

        wr(8'hFF, 0);                         // R2 locked write
        chk("R2 locked write ignored", rd_data, 0);
        wr(8'h0F, 1);                         // R10 bit3 dropped, R3 f32, R4
        chk("R10 bit3 reads zero", rd_data[3], 0);
        wr(8'h01, 1);
        wr(8'h02, 1);
        wr(8'h00, 1);                         // R3 gpio
        bus_mode = 1; step(2);                // R3 ale
        bus_mode = 0;
        wr(8'h10, 1);                         // R5 sub enable
        wr(8'h30, 1);                         // R6 pulse
        wr(8'h10, 1);
        ring_osc_mode = 1;
        wr(8'h30, 1);                         // R6 suppressed
        wr(8'h30, 1);                         // R6 already stopped
        ring_osc_mode = 0;
        wr(8'h00, 1);
        wr(8'h30, 1);                         // R9 clash
        wr(8'h00, 1);                         // R9 clash again
        wr(8'h40, 1);                         // R7 set
        wr(8'h00, 1);                         // R7 cannot clear
        chk("R7 sticky after clear", rd_data[6], 1);

        sub_stable = 0;
        wr(8'h91, 1);                         // R8 refused, others apply
        chk("R8 refused keeps main", rd_data, 8'h51);
        sub_stable = 1;
        wr(8'h90, 1);                         // R8 accepted
        chk("R8 sub taken", rd_data[7], 1);
        step(40);
        chk("R11 sub gate on", sub_gate_on, 1);
        chk("R11 main gate off", main_gate_on, 0);
        trace(1, "R12 follows sub");

        main_stable = 0;
        wr(8'h10, 1);                         // R8 refused back to main
        chk("R8 refused keeps sub", rd_data[7], 1);
        main_stable = 1;
        wr(8'h10, 1);
        chk("R8 main taken", rd_data[7], 0);
        step(40);
        chk("R11 main gate back", main_gate_on, 1);
        chk("R11 sub gate off", sub_gate_on, 0);
        trace(0, "R12 follows main");

        rst_n = 0; step(3); rst_n = 1; step(1);
        chk("R1 reset clears sticky", rd_data, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule